// File: doc/BRIEF.md
# Alert Line Latch and Alert-Response Responder

This block pulls a shared open-drain alert line low whenever one of its enabled status conditions fires, and holds it low until the host has serviced the alert. To find out which device is alerting, the host reads from the bus-wide alert-response address (7-bit value 0001100 with the read bit set). Every device with an unserviced alert acknowledges that byte and returns its own 7-bit address. Because SDA is a wired-AND line, the device with the lowest address wins bit-by-bit arbitration. A device that loses stops driving and waits for the next alert-response read.

The block does not detect bus conditions itself. A shared bit-level bus engine supplies single-cycle START, STOP, SCL-rising and SCL-falling strobes, together with the synchronized SDA level. The block returns one pull-low request for SDA and one for the alert line. A status-read strobe from the register side tells the block that the host has read the status registers. The latched conditions are then cleared, and any condition that is still present latches again. Register storage is handled elsewhere.

Top module: `smb_alert_resp`

## Requirements
- R1: In the cycle after an input condition is active with its enable bit set, `alert_low_o` is 1. A condition whose enable bit is 0 never asserts the alert.
- R2: Once asserted, the alert stays asserted after the condition goes away, for as long as no status-read strobe arrives.
- R3: A status-read strobe reloads the latch from the current enabled conditions. In the next cycle the alert is 0 if no enabled condition is active, and stays 1 if one is still active.
- R4: When an address byte equal to 8'h19 (0001100 followed by read bit 1) is received, and the alert is asserted and not yet acknowledged, SDA is pulled low from the SCL falling edge after the 8th bit until the SCL falling edge that ends the 9th clock.
- R5: The response byte is the 7-bit device address in bits 7..1 with bit 0 equal to 1, sent MSB first. Each bit is presented from one SCL falling edge to the next (a 0 pulls SDA low, a 1 releases it). SDA is released after the 8th data bit.
- R6: If the block releases SDA for a 1 but samples 0 at an SCL rising edge, it releases SDA for the rest of the byte. The alert stays asserted, and the block answers the next alert-response read.
- R7: A block that sends all 8 response bits without losing marks its alert as acknowledged. It does not acknowledge further alert-response reads until its alert has been released. A later new alert makes it answer again.
- R8: With no alert asserted, an alert-response read is not acknowledged and SDA is never pulled low.
- R9: Any other address byte (for example 8'h18, or the device's own address with the read bit) is not acknowledged by this block.
- R10: A START strobe restarts address reception at any point. A STOP strobe releases SDA in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | N_STATUS | Raw fault conditions |
| enable_i | input | N_STATUS | Per-condition alert enables |
| status_rd_i | input | 1 | One-cycle strobe: status registers were read |
| start_i | input | 1 | One-cycle START (or repeated START) strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| scl_rise_i | input | 1 | One-cycle SCL rising-edge strobe |
| scl_fall_i | input | 1 | One-cycle SCL falling-edge strobe |
| sda_i | input | 1 | Synchronized SDA line level |
| sda_low_o | output | 1 | 1 requests SDA pulled low |
| alert_low_o | output | 1 | 1 requests the alert line pulled low |

## Verification
The hardest case to reach is losing arbitration in the middle of the response byte while staying ready for the next read. A single responder on the bus never sees a 0 where it released the line. So the bench models a second alerting device on the wired-AND SDA net, with a lower address and its own arbitration rule. It then checks that the byte the host reads is the other device's byte, including bits where this block would have driven 0. A follow-up read without the competitor confirms that the alert is still pending. A competitor with a higher address covers the winning path and the acknowledged state that follows it.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACK,
        PH_DATA,
        PH_MACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic [7:0] resp_byte(input logic [6:0] dev);
        return {dev, 1'b1};
    endfunction

    function automatic logic is_ara_read(input logic [7:0] b);
        return b == {ARA_ADDR, 1'b1};
    endfunction

endpackage

// File: rtl/smb_alert_latch.sv
module smb_alert_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] enable_i,
    input  logic         status_rd_i,
    input  logic         win_i,
    output logic         alert_o,
    output logic         eligible_o
);
    logic [N-1:0] cond;
    logic [N-1:0] lat_q;
    logic [N-1:0] lat_d;
    logic         acked_q;

    assign cond = status_i & enable_i;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign lat_d[g] = status_rd_i ? cond[g] : (lat_q[g] | cond[g]);
        always_ff @(posedge clk) begin
            if (rst) lat_q[g] <= 1'b0;
            else     lat_q[g] <= lat_d[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 acked_q <= 1'b0;
        else if (lat_d == '0)    acked_q <= 1'b0;
        else if (win_i)          acked_q <= 1'b1;
    end

    assign alert_o    = |lat_q;
    assign eligible_o = alert_o && !acked_q;
endmodule

// File: rtl/smb_ara_seq.sv
module smb_ara_seq
    import smb_alert_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     sda_i,
    input  logic     eligible_i,
    output phase_e   phase_o,
    output logic     load_o,
    output logic     done_o
);
    phase_e     phase_q;
    logic [3:0] cnt_q;
    logic [7:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (evt.start) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (evt.stop) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_ADDR: begin
                    if (evt.rise && cnt_q != 4'd8) begin
                        shreg_q <= {shreg_q[6:0], sda_i};
                        cnt_q   <= cnt_q + 4'd1;
                    end else if (evt.fall && cnt_q == 4'd8) begin
                        phase_q <= (is_ara_read(shreg_q) && eligible_i) ? PH_ACK : PH_IDLE;
                        cnt_q   <= '0;
                    end
                end
                PH_ACK: begin
                    if (evt.fall) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end
                end
                PH_DATA: begin
                    if (evt.rise && cnt_q != 4'd8) cnt_q <= cnt_q + 4'd1;
                    else if (evt.fall && cnt_q == 4'd8) phase_q <= PH_MACK;
                end
                PH_MACK: begin
                    if (evt.fall) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign load_o  = (phase_q == PH_ACK) && evt.fall && !evt.start && !evt.stop;
    assign done_o  = (phase_q == PH_DATA) && evt.fall && (cnt_q == 4'd8)
                     && !evt.start && !evt.stop;
endmodule

// File: rtl/smb_ara_tx.sv
module smb_ara_tx
    import smb_alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       sda_i,
    input  logic       in_data_i,
    input  logic       load_i,
    input  logic       done_i,
    input  logic [7:0] resp_i,
    output logic       drive_o,
    output logic       won_o
);
    logic [7:0] txsh_q;
    logic       lost_q;
    logic       drive_q;

    always_ff @(posedge clk) begin
        if (rst || evt.start || evt.stop) begin
            txsh_q  <= '0;
            lost_q  <= 1'b0;
            drive_q <= 1'b0;
        end else if (load_i) begin
            txsh_q  <= resp_i;
            lost_q  <= 1'b0;
            drive_q <= ~resp_i[7];
        end else if (in_data_i) begin
            if (evt.rise && !lost_q && txsh_q[7] && !sda_i) begin
                lost_q  <= 1'b1;
                drive_q <= 1'b0;
            end else if (evt.fall) begin
                if (done_i) begin
                    drive_q <= 1'b0;
                end else begin
                    txsh_q  <= {txsh_q[6:0], 1'b0};
                    drive_q <= !lost_q && !txsh_q[6];
                end
            end
        end
    end

    assign drive_o = drive_q;
    assign won_o   = done_i && !lost_q;
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp
    import smb_alert_pkg::*;
#(
    parameter int         N_STATUS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h2E
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STATUS-1:0] status_i,
    input  logic [N_STATUS-1:0] enable_i,
    input  logic                status_rd_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                sda_i,
    output logic                sda_low_o,
    output logic                alert_low_o
);
    localparam logic [7:0] RESP = resp_byte(DEV_ADDR);

    bus_evt_t evt;
    phase_e   phase;
    logic     alert, eligible, win, load, done, data_low;
    logic     ack_slot, in_data;

    assign evt = '{start: start_i, stop: stop_i, rise: scl_rise_i, fall: scl_fall_i};

    smb_alert_latch #(.N(N_STATUS)) u_latch (
        .clk(clk), .rst(rst), .status_i(status_i), .enable_i(enable_i),
        .status_rd_i(status_rd_i), .win_i(win),
        .alert_o(alert), .eligible_o(eligible)
    );

    smb_ara_seq u_seq (
        .clk(clk), .rst(rst), .evt(evt), .sda_i(sda_i), .eligible_i(eligible),
        .phase_o(phase), .load_o(load), .done_o(done)
    );

    smb_ara_tx u_tx (
        .clk(clk), .rst(rst), .evt(evt), .sda_i(sda_i), .in_data_i(in_data),
        .load_i(load), .done_i(done), .resp_i(RESP),
        .drive_o(data_low), .won_o(win)
    );

    assign ack_slot    = (phase == PH_ACK);
    assign in_data     = (phase == PH_DATA);
    assign sda_low_o   = ack_slot | data_low;
    assign alert_low_o = alert;
endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] status_i,
    input logic [N-1:0] enable_i,
    input logic         status_rd_i,
    input logic         stop_i,
    input logic         scl_rise_i,
    input logic         sda_i,
    input logic         sda_low_o,
    input logic         alert_low_o,
    input logic         ack_slot,
    input logic         in_data
);
    AST_ALERT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|(status_i & enable_i)) |=> alert_low_o); // R1
    AST_ALERT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (alert_low_o && !status_rd_i) |=> alert_low_o); // R2
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (status_rd_i && !(|(status_i & enable_i))) |=> !alert_low_o); // R3
    AST_ACK_NEEDS_ALERT: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_slot) |-> $past(alert_low_o)); // R8
    AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (in_data && scl_rise_i && !sda_low_o && !sda_i) |=> !sda_low_o); // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !sda_low_o); // R10
endmodule

bind smb_alert_resp smb_alert_chk #(.N(N_STATUS)) u_chk (
    .clk(clk), .rst(rst), .status_i(status_i), .enable_i(enable_i),
    .status_rd_i(status_rd_i), .stop_i(stop_i), .scl_rise_i(scl_rise_i),
    .sda_i(sda_i), .sda_low_o(sda_low_o), .alert_low_o(alert_low_o),
    .ack_slot(ack_slot), .in_data(in_data)
);

// File: tb/sim_smb_alert_resp.sv
module sim_smb_alert_resp;
    localparam int         N   = 8;
    localparam logic [6:0] DEV = 7'h2E;
    localparam logic [7:0] MY_RESP = {DEV, 1'b1};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1;
    logic [N-1:0] status = '0, enable = '0;
    logic         status_rd = 0, start_s = 0, stop_s = 0, rise_s = 0, fall_s = 0;
    logic         m_sda = 1'b1, o_sda = 1'b1;
    logic         sda_low, alert_low;
    logic         sda_line;
    int           checks = 0, fails = 0;
    bit           done = 0;

    assign sda_line = m_sda & o_sda & ~sda_low;

    smb_alert_resp #(.N_STATUS(N), .DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst(rst), .status_i(status), .enable_i(enable),
        .status_rd_i(status_rd), .start_i(start_s), .stop_i(stop_s),
        .scl_rise_i(rise_s), .scl_fall_i(fall_s), .sda_i(sda_line),
        .sda_low_o(sda_low), .alert_low_o(alert_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk) start_s = 1'b1;
        @(negedge clk) start_s = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop_s = 1'b1;
        @(negedge clk) stop_s = 1'b0;
    endtask

    task automatic do_status_rd();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    task automatic clk_bit(input logic b, output logic rd);
        m_sda = b;
        @(negedge clk);
        rd = sda_line;
        rise_s = 1'b1;
        @(negedge clk) rise_s = 1'b0;
        @(negedge clk) fall_s = 1'b1;
        @(negedge clk) fall_s = 1'b0;
    endtask

    task automatic clear_all();
        status = '0;
        enable = '0;
        do_status_rd();
        idle(2);
    endtask

    task automatic raise_alert();
        enable = 8'h01;
        status = 8'h01;
        idle(2);
    endtask

    task automatic ara_read(input logic [7:0] addr_byte, input logic comp,
                            input logic [7:0] comp_byte, output logic acked,
                            output logic [7:0] got, output logic rel);
        logic r;
        logic olost;
        got = '0;
        rel = 1'b0;
        do_start();
        for (int i = 0; i < 8; i++) clk_bit(addr_byte[7-i], r);
        o_sda = comp ? 1'b0 : 1'b1;
        clk_bit(1'b1, r);
        o_sda = 1'b1;
        acked = !r;
        if (acked || comp) begin
            olost = 1'b0;
            for (int i = 0; i < 8; i++) begin
                o_sda = (comp && !olost) ? comp_byte[7-i] : 1'b1;
                clk_bit(1'b1, r);
                got[7-i] = r;
                if (comp && !olost && comp_byte[7-i] && !r) olost = 1'b1;
            end
            o_sda = 1'b1;
            rel = !sda_low;
            clk_bit(1'b1, r);
        end
        do_stop();
    endtask

    task automatic t_reset();
        chk("R1 reset alert", alert_low, 0);
        chk("R10 reset sda", sda_low, 0);
    endtask

    task automatic t_latch();
        enable = 8'h24;
        status = 8'h80;
        idle(3);
        chk("R1 disabled condition ignored", alert_low, 0);
        status = 8'h04;
        idle(1);
        chk("R1 enabled condition asserts", alert_low, 1);
        status = 8'h00;
        idle(3);
        chk("R2 alert held", alert_low, 1);
        do_status_rd();
        chk("R3 released after read", alert_low, 0);
        status = 8'h20;
        idle(1);
        chk("R1 second condition", alert_low, 1);
        do_status_rd();
        chk("R3 condition persists", alert_low, 1);
        status = 8'h00;
        do_status_rd();
        chk("R3 released once gone", alert_low, 0);
    endtask

    task automatic t_no_alert();
        logic a, rl; logic [7:0] g;
        clear_all();
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R8 no ack without alert", a, 0);
        chk("R8 sda released", sda_low, 0);
    endtask

    task automatic t_single();
        logic a, rl; logic [7:0] g;
        clear_all();
        raise_alert();
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R4 ara acked", a, 1);
        chk("R5 response byte", g, MY_RESP);
        chk("R5 released after byte", rl, 1);
        chk("R7 alert still low after win", alert_low, 1);
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R7 no ack once acknowledged", a, 0);
        clear_all();
        chk("R7 alert released", alert_low, 0);
        raise_alert();
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R7 new alert answers again", a, 1);
        chk("R5 response byte again", g, MY_RESP);
    endtask

    task automatic t_other_addr();
        logic a, rl; logic [7:0] g;
        clear_all();
        raise_alert();
        ara_read(8'h18, 1'b0, 8'h00, a, g, rl);
        chk("R9 ara write not acked", a, 0);
        ara_read({DEV, 1'b1}, 1'b0, 8'h00, a, g, rl);
        chk("R9 own address not acked", a, 0);
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R9 still answers ara", a, 1);
    endtask

    task automatic t_arb_lose();
        logic a, rl; logic [7:0] g;
        clear_all();
        raise_alert();
        ara_read(8'h19, 1'b1, {7'h10, 1'b1}, a, g, rl);
        chk("R6 host reads winner byte", g, 8'h21);
        chk("R6 alert kept after loss", alert_low, 1);
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R6 answers next ara", a, 1);
        chk("R6 byte after loss", g, MY_RESP);
    endtask

    task automatic t_arb_win();
        logic a, rl; logic [7:0] g;
        clear_all();
        raise_alert();
        ara_read(8'h19, 1'b1, {7'h7E, 1'b1}, a, g, rl);
        chk("R6 winner byte on bus", g, MY_RESP);
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R7 winner acknowledged", a, 0);
    endtask

    task automatic t_restart_stop();
        logic a, rl, r; logic [7:0] g;
        clear_all();
        raise_alert();
        do_start();
        for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
        ara_read(8'h19, 1'b0, 8'h00, a, g, rl);
        chk("R10 repeated start restarts", a, 1);
        clear_all();
        raise_alert();
        do_start();
        for (int i = 0; i < 8; i++) clk_bit(logic'(8'h19 >> (7 - i)), r);
        clk_bit(1'b1, r);
        chk("R4 ack seen", r, 0);
        clk_bit(1'b1, r);
        clk_bit(1'b1, r);
        chk("R5 driving bit5 zero", sda_low, 1);
        do_stop();
        chk("R10 stop releases sda", sda_low, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_latch();
        t_no_alert();
        t_single();
        t_other_addr();
        t_arb_lose();
        t_arb_win();
        t_restart_stop();
        done = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
        end
    end
endmodule